// File: doc/BRIEF.md
# Camera frame capture controller

This block moves one frame from a CMOS image sensor's parallel pixel port into an external asynchronous SRAM. The sensor supplies a frame sync, a line-valid level, a pixel clock and an 8-bit pixel bus. The block samples all of them in a faster system clock domain. It rejects short glitches on the sync lines and finds the start of a frame. It then stores every valid pixel at the next SRAM address, driving chip-enable, write and read strobes. Each pixel also carries a tag that gives its position in the raw Bayer mosaic.

After a full frame of `H_PIX` x `V_LINES` pixels has been stored (352 x 288 = 101376 by default), the block raises a completion flag and releases the SRAM so that the processor can read it. The flag stays high until the processor pulses an acknowledge, and no new frame is taken before then. If a new frame sync arrives before the pixel count is complete, the block reports an error flag for the short frame instead of the completion flag.

Top module: `cam_frame_capture`

## Requirements
- R1: After reset, `sram_ce_n_o`, `sram_we_n_o` and `sram_oe_n_o` are high, `sram_addr_o` is 0, and both `frame_done_o` and `frame_short_o` are low.
- R2: A rising edge on `vsync_i` counts only if the line is still high `GLITCH_DLY` system clocks after the synchronised edge. Shorter pulses are ignored. Capture begins at the next falling edge of `vsync_i`, and the first pixel of the frame is written at address 0.
- R3: A pixel is taken at each falling edge of `pclk_i` while `href_i` is high. Successive pixels of a frame are written to successive addresses, and the address advances by one when the write strobe returns high. Address and data are stable while the strobe is low.
- R4: `sram_we_n_o` goes low after a qualifying `pclk_i` fall and returns high after the next `pclk_i` rise. `sram_ce_n_o` is low only while a frame is being captured. `sram_oe_n_o` is always high.
- R5: `pix_color_o` tags each written pixel: 0 is blue, 1 is green, 2 is red. On the first line of a frame and on every second line after it, the tags run blue, green, blue, green and so on. On the other lines they run green, red, green, red and so on. The column position restarts on every line.
- R6: A falling edge of `href_i` ends a line only if `href_i` is still low `GLITCH_DLY` system clocks later. A shorter low pulse inside a line changes neither the line nor the column position used by R5.
- R7: When the `H_PIX*V_LINES`-th pixel of a frame has been written, `frame_done_o` rises. It stays high until `frame_ack_i` is sampled high, and no SRAM write or chip enable occurs while it is high. Frame syncs arriving while it is high are ignored.
- R8: A qualified `vsync_i` rise during capture, before the frame is complete, sets `frame_short_o` and leaves `frame_done_o` low. The next frame start clears `frame_short_o`, and that frame starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Sensor frame sync |
| href_i | input | 1 | Sensor line-valid level |
| pclk_i | input | 1 | Sensor pixel clock |
| pix_i | input | PIX_W | Sensor pixel bus |
| frame_ack_i | input | 1 | Processor acknowledge of a completed frame |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_data_o | output | PIX_W | SRAM write data |
| sram_ce_n_o | output | 1 | SRAM chip enable, active low |
| sram_we_n_o | output | 1 | SRAM write strobe, active low |
| sram_oe_n_o | output | 1 | SRAM read enable, active low |
| pix_color_o | output | 2 | Bayer tag of the pixel being written |
| frame_done_o | output | 1 | Full frame stored |
| frame_short_o | output | 1 | Frame ended before the full pixel count |

## Verification
The assertions rely on the sensor inputs changing slowly compared with the system clock. They assume that each pixel-clock half period lasts several system clocks, and that the pixel bus holds its value from one falling edge of the pixel clock to the next. They also assume that frame syncs never land while a write strobe is low, so every strobe rise during capture ends with an address step. The stimulus drives every sensor level for at least five system clocks, and makes its deliberate sync glitches shorter than the qualification delay. It places each frame sync well clear of the pixel activity.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    CLR_BLUE  = 2'd0,
    CLR_GREEN = 2'd1,
    CLR_RED   = 2'd2
  } bayer_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DONE    = 2'd3
  } cap_state_t;

endpackage

// File: rtl/cfc_sync.sv
module cfc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/cfc_edge_qual.sv
// Edge qualifier: an edge of the chosen polarity starts a delay; the edge is
// accepted only if the level still holds when the delay ends.
module cfc_edge_qual #(
  parameter int DLY       = 4,
  parameter bit RISE_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic acc
);

  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

  logic          prev_q;
  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          acc_q, acc_n;
  logic          edge_seen;
  logic          held;

  generate
    if (RISE_EDGE) begin : g_rise
      assign edge_seen = lvl & ~prev_q;
      assign held      = lvl;
    end else begin : g_fall
      assign edge_seen = ~lvl & prev_q;
      assign held      = ~lvl;
    end
  endgenerate

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    acc_n  = 1'b0;
    if (busy_q) begin
      if (cnt_q == CW'(DLY - 1)) begin
        busy_n = 1'b0;
        cnt_n  = '0;
        acc_n  = held;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (edge_seen) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/cfc_pix_track.sv
// Tracks line and column parity and gives the Bayer tag of the next pixel.
module cfc_pix_track
  import cfc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_start,
  input  logic   line_end,
  input  logic   pix_done,
  output bayer_t color
);

  logic col_odd_q, col_odd_n;
  logic line_odd_q, line_odd_n;

  always_comb begin
    col_odd_n  = col_odd_q;
    line_odd_n = line_odd_q;
    if (frame_start) begin
      col_odd_n  = 1'b0;
      line_odd_n = 1'b0;
    end else if (line_end) begin
      col_odd_n  = 1'b0;
      line_odd_n = ~line_odd_q;
    end else if (pix_done) begin
      col_odd_n = ~col_odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_odd_q  <= 1'b0;
      line_odd_q <= 1'b0;
    end else begin
      col_odd_q  <= col_odd_n;
      line_odd_q <= line_odd_n;
    end
  end

  always_comb begin
    if (!line_odd_q) color = col_odd_q ? CLR_GREEN : CLR_BLUE;
    else             color = col_odd_q ? CLR_RED   : CLR_GREEN;
  end

endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture
  import cfc_pkg::*;
#(
  parameter int H_PIX      = 352,
  parameter int V_LINES    = 288,
  parameter int ADDR_W     = 17,
  parameter int PIX_W      = 8,
  parameter int GLITCH_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              href_i,
  input  logic              pclk_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              frame_ack_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [PIX_W-1:0]  sram_data_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [1:0]        pix_color_o,
  output logic              frame_done_o,
  output logic              frame_short_o
);

  localparam int FRAME_PIX = H_PIX * V_LINES;
  localparam int CNT_W     = $clog2(FRAME_PIX + 1);
  localparam int SYNC_W    = 3 + PIX_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s_q;

  // sensor inputs into the system domain
  logic             vs_s, hr_s, pc_s;
  logic [PIX_W-1:0] pix_s;

  cfc_sync #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({vsync_i, href_i, pclk_i, pix_i}),
    .q    ({vs_s, hr_s, pc_s, pix_s})
  );

  logic vs_rise_ok, hr_fall_ok;

  cfc_edge_qual #(.DLY(GLITCH_DLY), .RISE_EDGE(1'b1)) u_vs_qual (
    .clk  (clk),
    .rst_n(rst_int_n),
    .lvl  (vs_s),
    .acc  (vs_rise_ok)
  );

  cfc_edge_qual #(.DLY(GLITCH_DLY), .RISE_EDGE(1'b0)) u_hr_qual (
    .clk  (clk),
    .rst_n(rst_int_n),
    .lvl  (hr_s),
    .acc  (hr_fall_ok)
  );

  logic pc_prev_q, vs_prev_q;
  logic pc_fall, pc_rise, vs_fall;
  assign pc_fall = pc_prev_q & ~pc_s;
  assign pc_rise = ~pc_prev_q & pc_s;
  assign vs_fall = vs_prev_q & ~vs_s;

  // control state
  cap_state_t        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              we_n_q, we_n_n;
  logic              ce_n_q, ce_n_n;
  logic [PIX_W-1:0]  data_q, data_n;
  bayer_t            color_q, color_n;
  logic              done_q, done_n;
  logic              short_q, short_n;
  logic              frame_start, pix_done, line_end;
  bayer_t            tag;

  assign line_end = hr_fall_ok && (state_q == ST_CAPTURE);

  cfc_pix_track u_track (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_start(frame_start),
    .line_end   (line_end),
    .pix_done   (pix_done),
    .color      (tag)
  );

  always_comb begin
    state_n     = state_q;
    addr_n      = addr_q;
    cnt_n       = cnt_q;
    we_n_n      = we_n_q;
    data_n      = data_q;
    color_n     = color_q;
    done_n      = done_q;
    short_n     = short_q;
    frame_start = 1'b0;
    pix_done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (vs_rise_ok) state_n = ST_ARMED;
      end
      ST_ARMED: begin
        if (vs_fall) begin
          state_n     = ST_CAPTURE;
          frame_start = 1'b1;
          addr_n      = '0;
          cnt_n       = '0;
          short_n     = 1'b0;
        end
      end
      ST_CAPTURE: begin
        if (vs_rise_ok) begin
          short_n = 1'b1;
          we_n_n  = 1'b1;
          state_n = ST_ARMED;
        end else if (!we_n_q) begin
          if (pc_rise) begin
            we_n_n   = 1'b1;
            addr_n   = addr_q + 1'b1;
            cnt_n    = cnt_q + 1'b1;
            pix_done = 1'b1;
            if (cnt_q == CNT_W'(FRAME_PIX - 1)) begin
              state_n = ST_DONE;
              done_n  = 1'b1;
            end
          end
        end else if (pc_fall && hr_s) begin
          we_n_n  = 1'b0;
          data_n  = pix_s;
          color_n = tag;
        end
      end
      ST_DONE: begin
        if (frame_ack_i) begin
          state_n = ST_IDLE;
          done_n  = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    ce_n_n = (state_n != ST_CAPTURE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      we_n_q    <= 1'b1;
      ce_n_q    <= 1'b1;
      data_q    <= '0;
      color_q   <= CLR_BLUE;
      done_q    <= 1'b0;
      short_q   <= 1'b0;
      pc_prev_q <= 1'b0;
      vs_prev_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      addr_q    <= addr_n;
      cnt_q     <= cnt_n;
      we_n_q    <= we_n_n;
      ce_n_q    <= ce_n_n;
      data_q    <= data_n;
      color_q   <= color_n;
      done_q    <= done_n;
      short_q   <= short_n;
      pc_prev_q <= pc_s;
      vs_prev_q <= vs_s;
    end
  end

  assign sram_addr_o   = addr_q;
  assign sram_data_o   = data_q;
  assign sram_ce_n_o   = ce_n_q;
  assign sram_we_n_o   = we_n_q;
  assign sram_oe_n_o   = 1'b1;
  assign pix_color_o   = color_q;
  assign frame_done_o  = done_q;
  assign frame_short_o = short_q;

endmodule

// File: rtl/cfc_capture_chk.sv
module cfc_capture_chk #(
  parameter int ADDR_W = 17,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] addr,
  input logic [PIX_W-1:0]  data,
  input logic              ce_n,
  input logic              we_n,
  input logic              done,
  input logic              short_flag
);

  p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && !short_flag) |-> (addr == $past(addr) + 1'b1));

  p_write_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!we_n) && !we_n) |-> ($stable(data) && $stable(addr)));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ack) |=> done);

  p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && we_n));

  p_short_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !short_flag);

endmodule

bind cam_frame_capture cfc_capture_chk #(
  .ADDR_W(ADDR_W),
  .PIX_W (PIX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (frame_ack_i),
  .addr      (sram_addr_o),
  .data      (sram_data_o),
  .ce_n      (sram_ce_n_o),
  .we_n      (sram_we_n_o),
  .done      (frame_done_o),
  .short_flag(frame_short_o)
);

// File: tb/cam_frame_capture_test.sv
module cam_frame_capture_test;

  localparam int H   = 8;
  localparam int V   = 4;
  localparam int FP  = H * V;
  localparam int AW  = 17;
  localparam int PW  = 8;
  localparam int DLY = 4;
  localparam int PH  = 5;

  logic          clk;
  logic          rst_n;
  logic          vsync, href, pclk, ack;
  logic [PW-1:0] pix;
  logic [AW-1:0] addr;
  logic [PW-1:0] data;
  logic          ce_n, we_n, oe_n, done, short_f;
  logic [1:0]    color;

  cam_frame_capture #(.H_PIX(H), .V_LINES(V), .ADDR_W(AW), .PIX_W(PW), .GLITCH_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .href_i(href), .pclk_i(pclk),
    .pix_i(pix), .frame_ack_i(ack), .sram_addr_o(addr), .sram_data_o(data),
    .sram_ce_n_o(ce_n), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n),
    .pix_color_o(color), .frame_done_o(done), .frame_short_o(short_f)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  bit mon_on = 0;
  bit finished = 0;

  // reference model state
  bit m_cap = 0, m_done = 0;
  int m_addr = 0, m_line = 0, m_col = 0;
  int q_addr[$], q_data[$], q_col[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bayer(input int ln, input int cl);
    if (ln % 2 == 0) return (cl % 2 == 0) ? 0 : 1;
    return (cl % 2 == 0) ? 1 : 2;
  endfunction

  task automatic send_pix(input int d);
    pclk = 1'b0;
    pix  = PW'(d);
    if (m_cap && href) begin
      q_addr.push_back(m_addr);
      q_data.push_back(d);
      q_col.push_back(bayer(m_line, m_col));
      m_addr++;
      m_col++;
      if (m_addr == FP) begin
        m_cap  = 0;
        m_done = 1;
      end
    end
    tick(PH);
    pclk = 1'b1;
    tick(PH);
  endtask

  task automatic send_line(input int base, input bit glitch);
    href = 1'b1;
    tick(3);
    for (int c = 0; c < H; c++) begin
      send_pix((base + c * 7) & 8'hff);
      if (glitch && c == 3) begin
        href = 1'b0;
        tick(2);
        href = 1'b1;
        tick(2);
      end
    end
    href = 1'b0;
    m_line++;
    m_col = 0;
    tick(20);
  endtask

  task automatic start_frame(input bit exp_short);
    vsync = 1'b1;
    tick(20);
    if (m_cap) m_cap = 0;
    chk(short_f == exp_short, "R8", "short flag after frame sync", short_f, exp_short);
    vsync = 1'b0;
    if (!m_done) begin
      m_cap  = 1;
      m_addr = 0;
      m_line = 0;
      m_col  = 0;
    end
    tick(10);
  endtask

  // monitor: compare every clock against the model
  logic          we_prev = 1'b1;
  logic [AW-1:0] hold_addr;
  logic [PW-1:0] hold_data;
  logic [1:0]    hold_col;
  always @(negedge clk) begin
    if (mon_on) begin
      chk(oe_n == 1'b1, "R4", "read enable", oe_n, 1);
      chk(we_n || !ce_n, "R4", "write without chip enable", ce_n, 0);
      if (!we_n) begin
        hold_addr = addr;
        hold_data = data;
        hold_col  = color;
      end else if (!we_prev) begin
        writes++;
        if (q_addr.size() == 0) begin
          chk(1'b0, "R7", "unexpected write at address", hold_addr, -1);
        end else begin
          chk(hold_addr == q_addr[0], "R3", "write address", hold_addr, q_addr[0]);
          chk(hold_data == q_data[0], "R3", "write data", hold_data, q_data[0]);
          chk(hold_col == q_col[0], "R5", "bayer tag", hold_col, q_col[0]);
          chk(addr == AW'(q_addr[0] + 1), "R3", "address after strobe", addr, q_addr[0] + 1);
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
          void'(q_col.pop_front());
        end
      end
      we_prev = we_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int w0;
  initial begin
    rst_n = 1'b0; vsync = 1'b0; href = 1'b0; pclk = 1'b1; ack = 1'b0; pix = '0;
    tick(5);
    chk(ce_n == 1 && we_n == 1 && oe_n == 1, "R1", "strobes in reset", {ce_n, we_n, oe_n}, 7);
    chk(addr == 0, "R1", "address in reset", addr, 0);
    chk(done == 0 && short_f == 0, "R1", "flags in reset", {done, short_f}, 0);
    rst_n = 1'b1;
    tick(5);
    mon_on = 1;

    // full frame, with an href glitch inside line 1 (R6)
    start_frame(1'b0);
    for (int l = 0; l < V; l++) send_line(16 * l + 1, l == 1);
    chk(done == 1, "R7", "done after full frame", done, 1);
    chk(short_f == 0, "R8", "no short on full frame", short_f, 0);
    chk(writes == FP, "R3", "write count", writes, FP);
    chk(q_addr.size() == 0, "R6", "pending expected writes", q_addr.size(), 0);

    // frame sent while done is pending is ignored
    w0 = writes;
    start_frame(1'b0);
    send_line(100, 1'b0);
    send_line(120, 1'b0);
    chk(writes == w0, "R7", "writes while done", writes, w0);
    chk(done == 1, "R7", "done held without ack", done, 1);
    chk(ce_n == 1, "R7", "chip enable while done", ce_n, 1);

    ack = 1'b1; tick(1); ack = 1'b0; tick(3);
    m_done = 0;
    chk(done == 0, "R7", "done after ack", done, 0);

    // glitch on vsync: no capture starts
    vsync = 1'b1; tick(2); vsync = 1'b0; tick(20);
    w0 = writes;
    send_line(40, 1'b0);
    send_line(60, 1'b0);
    chk(writes == w0, "R2", "writes after vsync glitch", writes, w0);
    chk(ce_n == 1, "R2", "chip enable after vsync glitch", ce_n, 1);

    // short frame, then a full frame from address 0
    start_frame(1'b0);
    send_line(3, 1'b0);
    send_line(33, 1'b0);
    start_frame(1'b1);
    chk(done == 0, "R8", "no done on short frame", done, 0);
    chk(short_f == 0, "R8", "short cleared at next frame start", short_f, 0);
    for (int l = 0; l < V; l++) send_line(9 * l + 200, 1'b0);
    chk(done == 1, "R2", "done after restarted frame", done, 1);
    chk(q_addr.size() == 0, "R2", "pending expected writes", q_addr.size(), 0);
    ack = 1'b1; tick(1); ack = 1'b0; tick(3);
    chk(done == 0, "R7", "done after second ack", done, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule